// File: doc/BRIEF.md
# Aspect-Configurable Dual-Port SRAM

This block is a 256-bit memory with one write port and one read port. Each port has its own clock and can work at the same time as the other. A static organisation input sets how the array is seen. It can be 32 words of 8 bits (byte organisation) or 64 words of 4 bits (nibble organisation). Both ports take a 6-bit address, an 8-bit write data input and an 8-bit registered read output. The same physical storage serves both organisations, so data written in one can be read back in the other.

Each port clock passes through a static polarity bit, so that port can act on the rising or the falling edge of its pin. A write needs two enables at the active write edge: a write enable and a block enable. The read output is a register. It loads only when the read enable is high at the active read edge. In all other cycles it keeps its value.

The storage itself has no reset. The read output register is cleared by an active-low reset input. The reset takes effect at once, and its release is synchronised to the active read edge.

Top module: `aspect_dpram`

## Requirements
- R1: With `org_nibble` = 0 (byte organisation), a write at address bits 4:0 stores all 8 bits of `wr_data`, and a read of that address returns the same 8 bits.
- R2: In byte organisation, address bit 5 has no effect on either port: addresses A and A+32 reach the same word.
- R3: With `org_nibble` = 1, a write stores `wr_data[3:0]` in the byte at address bits 5:1. Address bit 0 picks the lane: 0 is bits 3:0 and 1 is bits 7:4. The other nibble of that byte keeps its value.
- R4: In nibble organisation, a read returns the addressed nibble in `rd_data[3:0]` and drives `rd_data[7:4]` to zero.
- R5: The storage changes only when `wr_en` and `wr_blk_en` are both 1 at the active write edge. If either one is 0, nothing is written.
- R6: `rd_data` loads only when `rd_en` is 1 at the active read edge. Otherwise it holds its previous value, even if the stored word changes.
- R7: Each port has its own edge selection. `wr_clk_fall` = 1 or `rd_clk_fall` = 1 makes that port act on the falling edge of its clock; 0 selects the rising edge.
- R8: When both ports use the same clock edge and a read and a write target the same location at that edge, the read returns the contents from before the write.
- R9: When `rd_rst_n` goes low, `rd_data` becomes 0 without waiting for a clock edge. Reset release takes effect after two active read edges. The reset does not change the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write port clock |
| wr_clk_fall | input | 1 | Static: 1 = write port acts on the falling edge |
| wr_en | input | 1 | Write enable |
| wr_blk_en | input | 1 | Block enable; must be high together with wr_en |
| wr_addr | input | 6 | Write address |
| wr_data | input | 8 | Write data (nibble organisation uses bits 3:0) |
| rd_clk | input | 1 | Read port clock |
| rd_clk_fall | input | 1 | Static: 1 = read port acts on the falling edge |
| rd_rst_n | input | 1 | Active-low reset of the read output register |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 6 | Read address |
| rd_data | output | 8 | Registered read data |
| org_nibble | input | 1 | Static: 0 = 32x8, 1 = 64x4 |

## Verification
The bench writes through address A+32 in byte organisation and reads through A. A design that decoded bit 5 would miss the stored word. It writes both nibble lanes of one byte and reads the byte back in byte organisation. This exposes a design that overwrites the neighbouring nibble or swaps the lanes. It also hits the same location with both ports at one edge, where a write-first design would return the new data. With falling-edge polarity it samples between the falling edge and the next rising edge, where a design with the edge hard-wired would still show the old value. It also checks that `rd_data` holds while `rd_en` is low, and that a reset pulse leaves the stored data intact.

// File: rtl/aspect_dpram_pkg.sv
`timescale 1ns/1ps
package aspect_dpram_pkg;

  typedef enum logic {
    ORG_BYTE   = 1'b0,
    ORG_NIBBLE = 1'b1
  } org_e;

  // Take one half of a word: hi selects the upper half.
  function automatic logic [3:0] pick_half(input logic [7:0] word, input logic hi);
    return hi ? word[7:4] : word[3:0];
  endfunction

  // Put a 4-bit value into one half of a word and keep the other half.
  function automatic logic [7:0] merge_half(input logic [7:0] word,
                                            input logic [3:0] half,
                                            input logic       hi);
    return hi ? {half, word[3:0]} : {word[7:4], half};
  endfunction

endpackage

// File: rtl/dpram_clk_pol.sv
`timescale 1ns/1ps
module dpram_clk_pol (
  input  logic clk_in,
  input  logic fall_sel,
  output logic clk_out
);
  // Static polarity select: inverting the pin makes its falling edge the active edge.
  assign clk_out = clk_in ^ fall_sel;
endmodule

// File: rtl/dpram_addr_map.sv
`timescale 1ns/1ps
module dpram_addr_map #(
  parameter int ADDR_W = 6,
  localparam int BA_W  = ADDR_W - 1
) (
  input  logic              org_nibble,
  input  logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   byte_idx,
  output logic              half_hi
);
  always_comb begin
    if (org_nibble) begin
      byte_idx = addr[ADDR_W-1:1];
      half_hi  = addr[0];
    end else begin
      byte_idx = addr[BA_W-1:0];   // top address bit ignored
      half_hi  = 1'b0;
    end
  end
endmodule

// File: rtl/dpram_rst_sync.sv
`timescale 1ns/1ps
module dpram_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpram_rd_port.sv
`timescale 1ns/1ps
module dpram_rd_port
  import aspect_dpram_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              org_nibble,
  input  logic              half_hi,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] shaped;
  logic [WORD_W-1:0] data_d;
  logic [WORD_W-1:0] data_q;

  always_comb begin
    if (org_e'(org_nibble) == ORG_NIBBLE)
      shaped = {{HALF_W{1'b0}}, pick_half(word, half_hi)};
    else
      shaped = word;
  end

  always_comb begin
    data_d = data_q;
    if (rd_en) data_d = shaped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign rd_data = data_q;
endmodule

// File: rtl/aspect_dpram.sv
`timescale 1ns/1ps
module aspect_dpram
  import aspect_dpram_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 32,
  localparam int BA_W  = $clog2(DEPTH),
  localparam int ADDR_W = BA_W + 1
) (
  input  logic              wr_clk,
  input  logic              wr_clk_fall,
  input  logic              wr_en,
  input  logic              wr_blk_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_clk_fall,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              org_nibble
);
  logic              wr_clk_eff;
  logic              rd_clk_eff;
  logic              rd_rst_sync_n;
  logic [BA_W-1:0]   wr_byte;
  logic              wr_hi;
  logic [BA_W-1:0]   rd_byte;
  logic              rd_hi;
  logic              wr_fire;
  logic [WORD_W-1:0] wr_cur;
  logic [WORD_W-1:0] wr_merged;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] mem_q [DEPTH];

  dpram_clk_pol u_wr_pol (.clk_in(wr_clk), .fall_sel(wr_clk_fall), .clk_out(wr_clk_eff));
  dpram_clk_pol u_rd_pol (.clk_in(rd_clk), .fall_sel(rd_clk_fall), .clk_out(rd_clk_eff));

  dpram_addr_map #(.ADDR_W(ADDR_W)) u_wr_map (
    .org_nibble(org_nibble), .addr(wr_addr), .byte_idx(wr_byte), .half_hi(wr_hi)
  );
  dpram_addr_map #(.ADDR_W(ADDR_W)) u_rd_map (
    .org_nibble(org_nibble), .addr(rd_addr), .byte_idx(rd_byte), .half_hi(rd_hi)
  );

  dpram_rst_sync #(.STAGES(2)) u_rd_rst (
    .clk(rd_clk_eff), .rst_in_n(rd_rst_n), .rst_out_n(rd_rst_sync_n)
  );

  // Write side: next-state for the addressed byte
  always_comb begin
    wr_fire = wr_en & wr_blk_en;
    wr_cur  = mem_q[wr_byte];
    if (org_e'(org_nibble) == ORG_NIBBLE)
      wr_merged = merge_half(wr_cur, wr_data[WORD_W/2-1:0], wr_hi);
    else
      wr_merged = wr_data;
  end

  // Storage: no reset, write clock domain
  always_ff @(posedge wr_clk_eff) begin
    if (wr_fire) mem_q[wr_byte] <= wr_merged;
  end

  always_comb begin
    rd_word = mem_q[rd_byte];
  end

  dpram_rd_port #(.WORD_W(WORD_W)) u_rd_port (
    .clk(rd_clk_eff), .rst_n(rd_rst_sync_n), .rd_en(rd_en),
    .org_nibble(org_nibble), .half_hi(rd_hi), .word(rd_word), .rd_data(rd_data)
  );
endmodule

// File: rtl/aspect_dpram_chk.sv
`timescale 1ns/1ps
module aspect_dpram_chk #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 32,
  localparam int BA_W  = $clog2(DEPTH),
  localparam int ADDR_W = BA_W + 1
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              wr_blk_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              rd_en,
  input logic [WORD_W-1:0] rd_data,
  input logic              org_nibble,
  input logic [WORD_W-1:0] mem [DEPTH]
);
  // R1: a byte-organisation write lands in the word addressed by bits 4:0
  p_byte_write_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && wr_blk_en && !org_nibble)
      |=> mem[$past(wr_addr[BA_W-1:0])] === $past(wr_data));

  // R5: without both enables, the addressed byte is unchanged
  p_no_write_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    !(wr_en && wr_blk_en)
      |=> mem[$past(wr_addr[BA_W-1:0])] === $past(mem[wr_addr[BA_W-1:0]]));

  // R4: nibble reads clear the upper half of the output
  p_upper_zero_r4: assert property (@(posedge rclk) disable iff (!rst_n)
    (rd_en && org_nibble) |=> rd_data[WORD_W-1:WORD_W/2] == '0);

  // R6: output holds while read enable is low
  p_hold_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  // R9: output is zero whenever reset is low
  p_reset_zero_r9: assert property (@(posedge rclk)
    !rst_n |-> rd_data == '0);
endmodule

bind aspect_dpram aspect_dpram_chk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .wclk(wr_clk_eff), .rclk(rd_clk_eff), .rst_n(rd_rst_n),
  .wr_en(wr_en), .wr_blk_en(wr_blk_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .org_nibble(org_nibble), .mem(mem_q)
);

// File: tb/aspect_dpram_bench.sv
`timescale 1ns/1ps
module aspect_dpram_bench;
  logic       clk = 1'b0;
  logic       wr_clk_fall, wr_en, wr_blk_en, rd_clk_fall, rd_rst_n, rd_en, org_nibble;
  logic [5:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] model [32];
  logic [7:0] held;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  aspect_dpram u_aspect_dpram (
    .wr_clk(clk), .wr_clk_fall(wr_clk_fall), .wr_en(wr_en), .wr_blk_en(wr_blk_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(clk), .rd_clk_fall(rd_clk_fall), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .org_nibble(org_nibble)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic m, input logic [5:0] a);
    if (m) return {4'b0, a[0] ? model[a[5:1]][7:4] : model[a[5:1]][3:0]};
    return model[a[4:0]];
  endfunction

  task automatic model_write(input logic m, input logic [5:0] a, input logic [7:0] d);
    if (m) begin
      if (a[0]) model[a[5:1]][7:4] = d[3:0];
      else      model[a[5:1]][3:0] = d[3:0];
    end else begin
      model[a[4:0]] = d;
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    wr_en = 0; wr_blk_en = 0; rd_en = 0;
  endtask

  // Drive one cycle (same-edge ports), then check rd_data
  task automatic op(input string tag, input logic we, input logic be,
                    input logic [5:0] wa, input logic [7:0] wd,
                    input logic re, input logic [5:0] ra);
    wr_en = we; wr_blk_en = be; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    if (re) held = exp_read(org_nibble, ra);
    if (we && be) model_write(org_nibble, wa, wd);
    cyc();
    check(tag, rd_data, held);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    wr_clk_fall = 0; rd_clk_fall = 0; rd_rst_n = 1; org_nibble = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0;
    idle();
    for (int i = 0; i < 32; i++) model[i] = '0;
    #0.5 rd_rst_n = 0;
    #0.5 check("R9 reset state", rd_data, 8'h00);
    cyc(); cyc();
    rd_rst_n = 1;
    repeat (3) cyc();
    held = 8'h00;

    // R1: fill and read back in byte organisation
    for (int i = 0; i < 32; i++) op("R1", 1, 1, 6'(i), 8'($urandom), 0, 0);
    for (int i = 0; i < 32; i++) op("R1", 0, 0, 0, 0, 1, 6'(i));

    // R2: bit 5 ignored on both ports
    op("R2", 1, 1, 6'h25, 8'hA5, 0, 0);
    op("R2", 0, 0, 0, 0, 1, 6'h05);
    op("R2", 1, 1, 6'h06, 8'h5B, 0, 0);
    op("R2", 0, 0, 0, 0, 1, 6'h26);

    // R5: one enable alone writes nothing
    op("R5", 1, 0, 6'h03, 8'h11, 0, 0);
    op("R5", 0, 1, 6'h03, 8'h22, 0, 0);
    op("R5", 0, 0, 0, 0, 1, 6'h03);

    // R6: output holds while rd_en low even as the word changes
    op("R6", 0, 0, 0, 0, 1, 6'h04);
    op("R6", 1, 1, 6'h04, ~model[4], 0, 6'h04);
    op("R6", 0, 0, 0, 0, 0, 6'h09);

    // R8: same location, same edge -> old data
    op("R8", 1, 1, 6'h07, 8'h3C ^ model[7], 1, 6'h07);
    op("R8", 0, 0, 0, 0, 1, 6'h07);

    // R3/R4: nibble lanes
    org_nibble = 1;
    op("R3", 1, 1, 6'h10, 8'hF6, 0, 0);
    op("R3", 1, 1, 6'h11, 8'h09, 0, 0);
    op("R4", 0, 0, 0, 0, 1, 6'h11);
    op("R4", 0, 0, 0, 0, 1, 6'h10);
    org_nibble = 0;
    op("R3", 0, 0, 0, 0, 1, 6'h08);

    // Random traffic in both organisations
    for (int m = 0; m < 2; m++) begin
      org_nibble = m[0];
      for (int k = 0; k < 600; k++) begin
        logic re;
        re = ($urandom % 4) != 0;
        op(re ? (m[0] ? "R4" : "R1") : "R6",
           ($urandom % 3) != 0, ($urandom % 4) != 0,
           6'($urandom), 8'($urandom), re, 6'($urandom));
      end
    end
    org_nibble = 0;

    // R7: falling-edge polarity on both ports
    op("R7", 0, 0, 0, 0, 1, 6'h00);
    op("R7", 1, 1, 6'h01, ~model[0], 0, 0);
    idle();
    wr_clk_fall = 1; rd_clk_fall = 1;
    cyc();
    wr_en = 1; wr_blk_en = 1; wr_addr = 6'h02; wr_data = 8'h5A ^ model[2];
    rd_en = 1; rd_addr = 6'h01;
    held = model[1];
    model_write(0, 6'h02, 8'h5A ^ model[2]);
    #2;
    check("R7 fall edge read", rd_data, held);
    idle();
    #2;
    op("R7", 0, 0, 0, 0, 1, 6'h02);
    idle();
    wr_clk_fall = 0; rd_clk_fall = 0;
    cyc();
    op("R7", 0, 0, 0, 0, 1, 6'h02);

    // R9: mid-run reset clears output, keeps contents
    op("R9", 0, 0, 0, 0, 1, 6'h05);
    rd_rst_n = 0;
    #1 check("R9 async clear", rd_data, 8'h00);
    cyc();
    rd_rst_n = 1;
    repeat (3) cyc();
    held = 8'h00;
    op("R9", 0, 0, 0, 0, 1, 6'h05);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule